// File: doc/BRIEF.md
# Link-Layer Transmit Priority Arbiter

This block decides which pending item goes out next on the transmit side of a serial link. Eight sources raise request lines. They carry flow-control start-up packets, acknowledge/negative-acknowledge packets, credit-update packets, power-management packets, replayed transaction packets and fresh transaction packets. Acknowledge and credit-update traffic each has two request lines: an urgent line that ranks above all transaction data, and a relaxed line that ranks below it.

At a decision point the arbiter grants the highest-ranked active line and holds that one-hot grant until the granted source pulses end-of-packet. Once that strobe is consumed, the grant drops for one cycle and the next decision follows. A source that drives both lines of a pair is served by a single grant. When the urgent packet of a pair finishes, the relaxed line of that pair is ignored for the decision that follows, which gives the source a cycle to withdraw it.

Top module: `txPrioArb`

## Requirements
- R1: The `grant` output has at most one bit set in every cycle.
- R2: Bit i of `req` and of `grant` belongs to rank i, where rank 0 is the strongest: 0 flow-control start-up, 1 urgent ack/nak, 2 urgent credit update, 3 power management, 4 replayed transaction, 5 new transaction, 6 relaxed credit update, 7 relaxed ack/nak. At a decision point the lowest-numbered active bit is granted.
- R3: A replayed transaction request (bit 4) wins over a new transaction request (bit 5).
- R4: Urgent control requests (bits 1 and 2) and power management (bit 3) win over transaction requests, and relaxed control requests (bits 6 and 7) lose to them.
- R5: A decision happens at a clock edge where `grant` is zero. The grant appears in the cycle after that edge and holds unchanged, whatever `req` does, until `eop` is high at an edge.
- R6: The edge that samples `eop` high while a grant is held clears `grant`. The grant stays zero for one cycle, and the next decision is made at the following edge.
- R7: With no active request at a decision point, `grant` stays all zeros.
- R8: `eop` while `grant` is zero has no effect.
- R9: When an urgent pair member finishes (bit 1 or bit 2), the decision right after it ignores that pair's relaxed bit (bit 7 or bit 6). A later decision honours it again.
- R10: During and right after reset, `grant` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 8 | Request lines, bit index equals rank |
| eop | input | 1 | End-of-packet strobe from the granted source |
| grant | output | 8 | One-hot grant, zero when idle |

## Verification
Two events can fall in the same cycle: the end of an urgent pair packet, and the still-asserted relaxed request of the same pair reaching the next decision. The bench holds both lines of a pair high across the urgent packet's `eop`. It then checks that the decision after the gap skips the relaxed line, or grants a weaker requester, and that the relaxed line wins one decision later. Random bursts also hit `eop` in the cycle where new requests arrive. A reference model decides those cases.

// File: rtl/txarb_pkg.sv
package txarb_pkg;
  localparam int NUM_SRC = 8;
  localparam int IDX_W   = $clog2(NUM_SRC);

  // rank positions used by pairing logic
  localparam int ACK_URG = 1;
  localparam int UPD_URG = 2;
  localparam int UPD_REL = 6;
  localparam int ACK_REL = 7;

  typedef logic [NUM_SRC-1:0] srcVec_t;

  typedef struct packed {
    logic load;   // take the picked winner into the grant register
    logic clear;  // drop the grant after end of packet
  } arbStrobe_t;

  typedef enum logic {ST_IDLE, ST_BUSY} arbState_t;

  // relaxed-line mask raised by a finishing urgent grant
  function automatic srcVec_t relaxedPartner(input srcVec_t g);
    srcVec_t m;
    m = '0;
    m[ACK_REL] = g[ACK_URG];
    m[UPD_REL] = g[UPD_URG];
    return m;
  endfunction
endpackage

// File: rtl/txarb_ctrl.sv
module txarb_ctrl
  import txarb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       anyCand,
  input  logic       eop,
  output arbStrobe_t strobe
);
  arbState_t state, stateNext;

  always_comb begin
    stateNext    = state;
    strobe.load  = 1'b0;
    strobe.clear = 1'b0;
    unique case (state)
      ST_IDLE: if (anyCand) begin
        strobe.load = 1'b1;
        stateNext   = ST_BUSY;
      end
      ST_BUSY: if (eop) begin
        strobe.clear = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end
endmodule

// File: rtl/txarb_datapath.sv
module txarb_datapath
  import txarb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  srcVec_t    req,
  input  arbStrobe_t strobe,
  output logic       anyCand,
  output srcVec_t    grant
);
  srcVec_t skipMask;
  srcVec_t cand;
  srcVec_t pick;
  logic [NUM_SRC:0] seen;

  assign cand    = req & ~skipMask;
  assign anyCand = |cand;

  // fixed-priority pick: lowest index wins
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pick
    assign pick[i]   = cand[i] & ~seen[i];
    assign seen[i+1] = seen[i] | cand[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant    <= '0;
      skipMask <= '0;
    end else begin
      if (strobe.clear)     grant <= '0;
      else if (strobe.load) grant <= pick;
      // mask lives only for the decision right after a clear
      skipMask <= strobe.clear ? relaxedPartner(grant) : '0;
    end
  end
endmodule

// File: rtl/txPrioArb.sv
module txPrioArb
  import txarb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic               eop,
  output logic [NUM_SRC-1:0] grant
);
  arbStrobe_t strobe;
  logic       anyCand;

  txarb_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .anyCand(anyCand), .eop(eop), .strobe(strobe)
  );

  txarb_datapath dp_i (
    .clk(clk), .rst_n(rst_n), .req(req), .strobe(strobe),
    .anyCand(anyCand), .grant(grant)
  );
endmodule

// File: rtl/txPrioArb_chk.sv
module txPrioArb_chk
  import txarb_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] req,
  input logic               eop,
  input logic [NUM_SRC-1:0] grant
);
  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !eop) |=> $stable(grant));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && eop) |=> grant == '0);

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && req == '0) |=> grant == '0);

  assert_winner_requested_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0) |=> ((grant & $past(req)) == grant));

  assert_reset_R10: assert property (@(posedge clk)
    !rst_n |=> grant == '0);
endmodule

bind txPrioArb txPrioArb_chk chk_i (.*);

// File: tb/txPrioArb_tb_top.sv
module txPrioArb_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic       eop = 1'b0;
  logic [7:0] grant;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] mGrant = '0;
  logic [7:0] mMask  = '0;

  always #2 clk = ~clk;

  txPrioArb dut_i (.clk(clk), .rst_n(rst_n), .req(req), .eop(eop), .grant(grant));

  function automatic logic [7:0] lowestBit(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return 8'(1) << i;
    return '0;
  endfunction

  task automatic check(input logic [7:0] exp, input string tag);
    nChecks++;
    if (grant !== exp) begin
      nFails++;
      $display("FAIL %s grant=%b expected=%b", tag, grant, exp);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic [7:0] r, input logic e, input string tag);
    logic [7:0] nextMask;
    req = r; eop = e;
    @(posedge clk);
    nextMask = '0;
    if (mGrant != '0) begin
      if (e) begin
        nextMask[7] = mGrant[1];
        nextMask[6] = mGrant[2];
        mGrant = '0;
      end
    end else begin
      mGrant = lowestBit(r & ~mMask);
    end
    mMask = nextMask;
    @(negedge clk);
    check(mGrant, tag);
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(8'h00, "R10 in reset");
    rst_n = 1'b1;
    step(8'h00, 1'b0, "R10 after reset");
    step(8'h00, 1'b0, "R7 idle");
    step(8'h00, 1'b1, "R8 eop idle");
    // each source alone
    for (int i = 0; i < 8; i++) begin
      step(8'(1) << i, 1'b0, "R2 single");
      step(8'(1) << i, 1'b1, "R6 release");
      step(8'h00, 1'b0, "R6 gap");
    end
    step(8'h30, 1'b0, "R3 replay over new");
    step(8'h30, 1'b1, "R6");
    step(8'h20, 1'b0, "R3 new after");
    step(8'h00, 1'b1, "R6");
    step(8'hE0, 1'b0, "R4 new over relaxed");
    step(8'h01, 1'b0, "R5 hold despite req");
    step(8'hC8, 1'b1, "R6");
    step(8'hC8, 1'b0, "R4 pm over relaxed");
    step(8'h00, 1'b1, "R6");
    step(8'hFF, 1'b0, "R2 all on");
    step(8'hFF, 1'b1, "R6");
    // pair service
    step(8'h82, 1'b0, "R9 urgent ack first");
    step(8'h82, 1'b1, "R9 end urgent");
    step(8'h80, 1'b0, "R9 relaxed masked");
    step(8'h80, 1'b0, "R9 relaxed later");
    step(8'h00, 1'b1, "R6");
    step(8'h44, 1'b0, "R9 urgent upd");
    step(8'h64, 1'b1, "R9 end upd");
    step(8'h60, 1'b0, "R9 new wins over masked");
    step(8'h40, 1'b1, "R6");
    step(8'h40, 1'b0, "R9 relaxed upd granted");
    step(8'h00, 1'b1, "R6");
    // random
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] r;
      r = 8'($urandom);
      if ($urandom_range(3) == 0) r = '0;
      step(r, ($urandom_range(2) == 0), "R2 R5 random");
    end
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule